// File: doc/BRIEF.md
# DMA Channel Enable and Pending Register Bank

This block is the global control and status register bank of a 32-channel DMA engine. It keeps four per-channel bit vectors: hardware request enables, error interrupt enables, transfer-done pending flags and error pending flags. It also keeps a control word that the channel arbiter and the engines read. Software reaches it over a simple register bus that carries byte, halfword and word accesses. Hardware reaches it through per-channel done and error event inputs, which raise the pending flags.

Next to the full-width vectors, the bank decodes eight one-byte command registers. Each command takes a channel number and sets or clears one bit, so a driver can change one channel without a read-modify-write of a shared 32-bit vector. Two of the commands do not touch stored state. They send one-cycle start and done-clear pulses to the channel engines.

A strap input selects big-endian lane addressing. In that mode the bus address of a sub-word access is converted before decode, so software can use the same offsets in either mode. The bank drives the request enable vector, the control word, the two pulse vectors, and two interrupt lines: one for completed transfers and one for enabled errors.

Top module: `dmaChanRegBank`

## Requirements
- R1: After reset, every vector, the control word, both pulse vectors, both interrupt lines and every readable register are zero.
- R2: A write to the control word (offset 0x00) keeps only bits 1 to 7, 16 and 17 (mask 0x000300FE). The request enable vector (0x0C) and the error interrupt enable vector (0x14) store written data and read it back. Sub-word writes change only the addressed byte lanes.
- R3: A command byte written to 0x1B sets the request enable bit of one channel, and a command byte written to 0x1A clears it. Bits 4:0 of the command byte select the channel and bit 5 is ignored.
- R4: Command bytes at 0x19 and 0x18 set and clear one error interrupt enable bit in the same way.
- R5: A command byte at 0x1F clears only the selected channel's done pending bit. A command byte at 0x1E clears only the selected channel's error pending bit.
- R6: In any command byte, bit 7 high makes the command do nothing. Otherwise, bit 6 high applies the command to all channels.
- R7: A high bit on the done or error event input sets the matching pending bit. If a clear by command or by write-one-to-clear hits the same bit in the same cycle, the event wins.
- R8: Word writes to 0x24 (done pending) and 0x2C (error pending) clear every bit written as one. Bits written as zero are left alone.
- R9: The transfer interrupt is the OR of all done pending bits. The error interrupt is the OR of the error pending bits that also have their error interrupt enable bit set.
- R10: Access size is coded 0 for byte, 1 for halfword and 2 for word. With the big-endian strap high, a byte access uses address XOR 3 and a halfword access uses address XOR 2. Reads return the addressed lane right-aligned in the read data.
- R11: A command at 0x1D pulses the selected channels on the start output. A command at 0x1C pulses them on the done-clear output. Each pulse lasts exactly one cycle, the cycle after the write.
- R12: The error status register (0x04) reads bit 31 as the OR of all error pending bits. Bits 4:0 hold the lowest-numbered channel with a pending error, or 0 when none is pending.
- R13: A word write to 0x18 or 0x1C runs all four command bytes in that word in the same cycle. When a set and a clear select the same bit, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bigEndian | input | 1 | Strap that selects big-endian lane addressing |
| busWrEn | input | 1 | Write strobe for the current bus access |
| busSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| busAddr | input | 8 | Byte address of the access |
| busWdata | input | 32 | Write data, right-aligned |
| busRdata | output | 32 | Read data for the current address, right-aligned |
| doneEvt | input | 32 | Per-channel transfer-done events |
| errEvt | input | 32 | Per-channel error events |
| reqEnable | output | 32 | Request enable vector |
| ctrlCfg | output | 32 | Control word |
| chanStart | output | 32 | One-cycle start pulses |
| chanDoneClr | output | 32 | One-cycle done-clear pulses |
| xferIrq | output | 1 | Transfer interrupt |
| errIrq | output | 1 | Error interrupt |

## Verification
The key coincidence is a hardware event and a software clear that hit the same pending bit in the same cycle. A second one is a set command and a clear command that reach one vector bit through a single word write to a command pair. Directed cycles create both cases on chosen channels: a done event for channel 7 together with a clear-interrupt command for channel 7, and a word write whose set and clear bytes both name channel 5. The random phase places sparse event vectors beside random commands and write-one-to-clear words, so the same collisions also occur by chance. After every clock edge the bench compares the outputs with a reference model that applies clears first and then sets, and it compares readback at varied sizes and lanes in both endian modes.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;
  localparam int NUM_CH = 32;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int LANES = DATA_W / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ESTAT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_REQEN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ERRIEN  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CMDLO   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CMDHI   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_INTPEND = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_ERRPEND = 8'h2C;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0003_00FE;

  // Strobes from the decoder to the storage
  typedef struct packed {
    logic [DATA_W-1:0] wrData;
    logic [DATA_W-1:0] wrMask;
    logic              selCtrl;
    logic              selReqEn;
    logic              selErrIen;
    logic              selIntW1c;
    logic              selErrW1c;
    logic [NUM_CH-1:0] reqSet;
    logic [NUM_CH-1:0] reqClr;
    logic [NUM_CH-1:0] eeiSet;
    logic [NUM_CH-1:0] eeiClr;
    logic [NUM_CH-1:0] intClr;
    logic [NUM_CH-1:0] errClr;
    logic [NUM_CH-1:0] startSet;
    logic [NUM_CH-1:0] doneClr;
  } strobeT;

  // Turn a command byte into a channel vector
  function automatic logic [NUM_CH-1:0] decodeCmd(input logic [7:0] cmd);
    logic [NUM_CH-1:0] vec;
    if (cmd[7])      vec = '0;
    else if (cmd[6]) vec = '1;
    else             vec = {{(NUM_CH-1){1'b0}}, 1'b1} << cmd[CH_W-1:0];
    return vec;
  endfunction
endpackage

// File: rtl/dmaChanRegCtrl.sv
module dmaChanRegCtrl
  import dmaRegPkg::*;
(
  input  logic              bigEndian,
  input  logic              busWrEn,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobeT            strb,
  output logic [ADDR_W-3:0] rdWord,
  output logic [1:0]        laneOff
);
  logic [1:0]        swz;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] wordAddr;
  logic [LANES-1:0]  byteEn;
  logic              cmdLoHit;
  logic              cmdHiHit;

  always_comb begin
    swz = 2'b00;
    case (busSize)
      SZ_BYTE: swz = bigEndian ? 2'b11 : 2'b00;
      SZ_HALF: swz = bigEndian ? 2'b10 : 2'b00;
      default: swz = 2'b00;
    endcase
    effAddr = busAddr ^ {{(ADDR_W-2){1'b0}}, swz};
    case (busSize)
      SZ_BYTE: begin
        laneOff = effAddr[1:0];
        byteEn  = 4'b0001 << effAddr[1:0];
      end
      SZ_HALF: begin
        laneOff = {effAddr[1], 1'b0};
        byteEn  = 4'b0011 << {effAddr[1], 1'b0};
      end
      default: begin
        laneOff = 2'b00;
        byteEn  = 4'b1111;
      end
    endcase
    wordAddr = {effAddr[ADDR_W-1:2], 2'b00};
    rdWord   = effAddr[ADDR_W-1:2];

    strb = '0;
    strb.wrData = busWdata << {laneOff, 3'b000};
    for (int i = 0; i < LANES; i++) strb.wrMask[8*i +: 8] = {8{byteEn[i]}};
    strb.selCtrl   = busWrEn && (wordAddr == OFF_CTRL);
    strb.selReqEn  = busWrEn && (wordAddr == OFF_REQEN);
    strb.selErrIen = busWrEn && (wordAddr == OFF_ERRIEN);
    strb.selIntW1c = busWrEn && (wordAddr == OFF_INTPEND);
    strb.selErrW1c = busWrEn && (wordAddr == OFF_ERRPEND);

    cmdLoHit = busWrEn && (wordAddr == OFF_CMDLO);
    cmdHiHit = busWrEn && (wordAddr == OFF_CMDHI);
    // lane order fixes which command each byte address runs
    if (cmdLoHit && byteEn[0]) strb.eeiClr   = decodeCmd(strb.wrData[7:0]);
    if (cmdLoHit && byteEn[1]) strb.eeiSet   = decodeCmd(strb.wrData[15:8]);
    if (cmdLoHit && byteEn[2]) strb.reqClr   = decodeCmd(strb.wrData[23:16]);
    if (cmdLoHit && byteEn[3]) strb.reqSet   = decodeCmd(strb.wrData[31:24]);
    if (cmdHiHit && byteEn[0]) strb.doneClr  = decodeCmd(strb.wrData[7:0]);
    if (cmdHiHit && byteEn[1]) strb.startSet = decodeCmd(strb.wrData[15:8]);
    if (cmdHiHit && byteEn[2]) strb.errClr   = decodeCmd(strb.wrData[23:16]);
    if (cmdHiHit && byteEn[3]) strb.intClr   = decodeCmd(strb.wrData[31:24]);
  end
endmodule

// File: rtl/dmaChanRegDp.sv
module dmaChanRegDp
  import dmaRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-3:0] rdWord,
  input  logic [1:0]        laneOff,
  input  logic [1:0]        busSize,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] errEvt,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] reqEnable,
  output logic [DATA_W-1:0] ctrlCfg,
  output logic [NUM_CH-1:0] chanStart,
  output logic [NUM_CH-1:0] chanDoneClr,
  output logic              xferIrq,
  output logic              errIrq
);
  logic [DATA_W-1:0] ctrlQ, ctrlD;
  logic [NUM_CH-1:0] reqQ, reqD, eeiQ, eeiD, intQ, intD, errQ, errD;
  logic [NUM_CH-1:0] wrVec, wrMaskVec, intW1c, errW1c;
  logic [CH_W-1:0]   firstErr;
  logic [DATA_W-1:0] estat, rdWordVal, rdMask;

  always_comb begin
    wrVec     = strb.wrData[NUM_CH-1:0];
    wrMaskVec = strb.wrMask[NUM_CH-1:0];
    ctrlD = strb.selCtrl ? (((ctrlQ & ~strb.wrMask) | (strb.wrData & strb.wrMask)) & CTRL_MASK)
                         : ctrlQ;
    reqD = strb.selReqEn ? ((reqQ & ~wrMaskVec) | (wrVec & wrMaskVec)) : reqQ;
    reqD = (reqD & ~strb.reqClr) | strb.reqSet;
    eeiD = strb.selErrIen ? ((eeiQ & ~wrMaskVec) | (wrVec & wrMaskVec)) : eeiQ;
    eeiD = (eeiD & ~strb.eeiClr) | strb.eeiSet;
    intW1c = strb.selIntW1c ? (wrVec & wrMaskVec) : '0;
    errW1c = strb.selErrW1c ? (wrVec & wrMaskVec) : '0;
    // events are applied last so they beat a clear in the same cycle
    intD = (intQ & ~(strb.intClr | intW1c)) | doneEvt;
    errD = (errQ & ~(strb.errClr | errW1c)) | errEvt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ       <= '0;
      reqQ        <= '0;
      eeiQ        <= '0;
      intQ        <= '0;
      errQ        <= '0;
      chanStart   <= '0;
      chanDoneClr <= '0;
    end else begin
      ctrlQ       <= ctrlD;
      reqQ        <= reqD;
      eeiQ        <= eeiD;
      intQ        <= intD;
      errQ        <= errD;
      chanStart   <= strb.startSet;
      chanDoneClr <= strb.doneClr;
    end
  end

  always_comb begin
    firstErr = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) if (errQ[i]) firstErr = CH_W'(i);
    estat = '0;
    estat[DATA_W-1]   = |errQ;
    estat[CH_W-1:0]   = firstErr;
  end

  always_comb begin
    case ({rdWord, 2'b00})
      OFF_CTRL:    rdWordVal = ctrlQ;
      OFF_ESTAT:   rdWordVal = estat;
      OFF_REQEN:   rdWordVal = DATA_W'(reqQ);
      OFF_ERRIEN:  rdWordVal = DATA_W'(eeiQ);
      OFF_INTPEND: rdWordVal = DATA_W'(intQ);
      OFF_ERRPEND: rdWordVal = DATA_W'(errQ);
      default:     rdWordVal = '0;
    endcase
    case (busSize)
      SZ_BYTE: rdMask = 32'h0000_00FF;
      SZ_HALF: rdMask = 32'h0000_FFFF;
      default: rdMask = '1;
    endcase
    busRdata = (rdWordVal >> {laneOff, 3'b000}) & rdMask;
  end

  assign reqEnable = reqQ;
  assign ctrlCfg   = ctrlQ;
  assign xferIrq   = |intQ;
  assign errIrq    = |(errQ & eeiQ);
endmodule

// File: rtl/dmaChanRegBank.sv
module dmaChanRegBank
  import dmaRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic              busWrEn,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] errEvt,
  output logic [NUM_CH-1:0] reqEnable,
  output logic [DATA_W-1:0] ctrlCfg,
  output logic [NUM_CH-1:0] chanStart,
  output logic [NUM_CH-1:0] chanDoneClr,
  output logic              xferIrq,
  output logic              errIrq
);
  strobeT            strb;
  logic [ADDR_W-3:0] rdWord;
  logic [1:0]        laneOff;

  dmaChanRegCtrl i_ctrl (
    .bigEndian (bigEndian),
    .busWrEn   (busWrEn),
    .busSize   (busSize),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .strb      (strb),
    .rdWord    (rdWord),
    .laneOff   (laneOff)
  );

  dmaChanRegDp i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdWord      (rdWord),
    .laneOff     (laneOff),
    .busSize     (busSize),
    .doneEvt     (doneEvt),
    .errEvt      (errEvt),
    .busRdata    (busRdata),
    .reqEnable   (reqEnable),
    .ctrlCfg     (ctrlCfg),
    .chanStart   (chanStart),
    .chanDoneClr (chanDoneClr),
    .xferIrq     (xferIrq),
    .errIrq      (errIrq)
  );
endmodule

// File: rtl/dmaChanRegChk.sv
module dmaChanRegChk
  import dmaRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [NUM_CH-1:0] doneEvt,
  input logic [NUM_CH-1:0] errEvt,
  input logic [NUM_CH-1:0] reqEnable,
  input logic [DATA_W-1:0] ctrlCfg,
  input logic [NUM_CH-1:0] chanStart,
  input logic [NUM_CH-1:0] chanDoneClr,
  input logic              xferIrq,
  input logic              errIrq
);
  AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlCfg & ~CTRL_MASK) == '0); // R2
  AST_REQ_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(reqEnable)); // R3
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> (chanStart == '0 && chanDoneClr == '0)); // R11
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt != '0) |=> xferIrq); // R7
  AST_XFER_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferIrq) |-> $past(doneEvt != '0)); // R9
  AST_ERR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errIrq) |-> ($past(busWrEn) || $past(errEvt != '0))); // R9
endmodule

bind dmaChanRegBank dmaChanRegChk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busWrEn     (busWrEn),
  .doneEvt     (doneEvt),
  .errEvt      (errEvt),
  .reqEnable   (reqEnable),
  .ctrlCfg     (ctrlCfg),
  .chanStart   (chanStart),
  .chanDoneClr (chanDoneClr),
  .xferIrq     (xferIrq),
  .errIrq      (errIrq)
);

// File: tb/test_dmaChanRegBank.sv
module test_dmaChanRegBank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndian = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busSize = 2'd2;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] doneEvt = '0;
  logic [31:0] errEvt = '0;
  logic [31:0] reqEnable, ctrlCfg, chanStart, chanDoneClr;
  logic        xferIrq, errIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mCtrl = '0, mReq = '0, mEei = '0, mInt = '0, mErr = '0, mStart = '0, mDclr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaChanRegBank i_dmaChanRegBank (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .busWrEn(busWrEn), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .doneEvt(doneEvt),
    .errEvt(errEvt), .reqEnable(reqEnable), .ctrlCfg(ctrlCfg), .chanStart(chanStart),
    .chanDoneClr(chanDoneClr), .xferIrq(xferIrq), .errIrq(errIrq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdVec(input logic [7:0] v);
    if (v >= 8'd128) return 32'h0;
    if (v >= 8'd64) return 32'hFFFF_FFFF;
    return 32'h1 << (v % 32);
  endfunction

  function automatic logic [7:0] effOf(input logic [1:0] sz, input logic [7:0] a);
    if (!bigEndian) return a;
    if (sz == 2'd0) return a ^ 8'h03;
    if (sz == 2'd1) return a ^ 8'h02;
    return a;
  endfunction

  function automatic logic [31:0] modelRead(input logic [1:0] sz, input logic [7:0] a);
    logic [7:0] e;
    logic [31:0] w, es;
    int off;
    e = effOf(sz, a);
    es = 32'h0;
    for (int i = 31; i >= 0; i--) if (mErr[i]) es = 32'h8000_0000 | i;
    case (e[7:2])
      6'h00: w = mCtrl;
      6'h01: w = es;
      6'h03: w = mReq;
      6'h05: w = mEei;
      6'h09: w = mInt;
      6'h0B: w = mErr;
      default: w = 32'h0;
    endcase
    off = (sz == 2'd0) ? int'(e[1:0]) : (sz == 2'd1) ? 2 * int'(e[1]) : 0;
    w = w >> (8 * off);
    if (sz == 2'd0) w &= 32'hFF;
    else if (sz == 2'd1) w &= 32'hFFFF;
    return w;
  endfunction

  task automatic modelStep(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                           input logic [31:0] d, input logic [31:0] dn, input logic [31:0] er);
    logic [31:0] rs = 0, rc = 0, es = 0, ec = 0, ic = 0, xc = 0, st = 0, dc = 0;
    logic [7:0] e, ra, v;
    int n;
    if (wr) begin
      e = effOf(sz, a);
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      e = e & ~8'(n - 1);
      for (int k = 0; k < n; k++) begin
        ra = e + 8'(k);
        v = d[8*k +: 8];
        case (ra)
          8'h00, 8'h01, 8'h02, 8'h03: mCtrl[8*ra[1:0] +: 8] = v;
          8'h0C, 8'h0D, 8'h0E, 8'h0F: mReq[8*ra[1:0] +: 8] = v;
          8'h14, 8'h15, 8'h16, 8'h17: mEei[8*ra[1:0] +: 8] = v;
          8'h24, 8'h25, 8'h26, 8'h27: ic[8*ra[1:0] +: 8] = v;
          8'h2C, 8'h2D, 8'h2E, 8'h2F: xc[8*ra[1:0] +: 8] = v;
          8'h18: ec = cmdVec(v);
          8'h19: es = cmdVec(v);
          8'h1A: rc = cmdVec(v);
          8'h1B: rs = cmdVec(v);
          8'h1C: dc = cmdVec(v);
          8'h1D: st = cmdVec(v);
          8'h1E: xc = xc | cmdVec(v);
          8'h1F: ic = ic | cmdVec(v);
          default: ;
        endcase
      end
    end
    mCtrl &= 32'h0003_00FE;
    mReq = (mReq & ~rc) | rs;
    mEei = (mEei & ~ec) | es;
    mInt = (mInt & ~ic) | dn;
    mErr = (mErr & ~xc) | er;
    mStart = st;
    mDclr = dc;
  endtask

  task automatic cycle(input bit wr, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] dn, input logic [31:0] er, input bit rdChk, input string tag);
    @(negedge clk);
    busWrEn = wr; busSize = sz; busAddr = a; busWdata = d; doneEvt = dn; errEvt = er;
    #1;
    if (rdChk) chk(tag, "busRdata", busRdata, modelRead(sz, a));
    @(posedge clk);
    #1;
    modelStep(wr, sz, a, d, dn, er);
    chk(tag, "reqEnable", reqEnable, mReq);
    chk(tag, "ctrlCfg", ctrlCfg, mCtrl);
    chk(tag, "chanStart", chanStart, mStart);
    chk(tag, "chanDoneClr", chanDoneClr, mDclr);
    chk(tag, "xferIrq", 32'(xferIrq), 32'(|mInt));
    chk(tag, "errIrq", 32'(errIrq), 32'(|(mErr & mEei)));
  endtask

  task automatic randomPhase(input int cnt);
    logic [7:0] regs [7] = '{8'h00, 8'h04, 8'h0C, 8'h14, 8'h18, 8'h24, 8'h2C};
    logic [7:0] wregs [5] = '{8'h00, 8'h0C, 8'h14, 8'h24, 8'h2C};
    logic [7:0] hregs [3] = '{8'h00, 8'h0C, 8'h14};
    for (int i = 0; i < cnt; i++) begin
      int op;
      logic [31:0] dn, er, v;
      logic [7:0] a;
      logic [1:0] sz;
      op = int'($urandom % 10);
      dn = ($urandom % 2 == 0) ? 32'h0 : ($urandom & $urandom & $urandom & $urandom);
      er = ($urandom % 3 == 0) ? ($urandom & $urandom & $urandom & $urandom) : 32'h0;
      if (op < 6) begin
        a = 8'h18 + 8'($urandom % 8);
        v = ($urandom % 100 < 75) ? (($urandom % 32) | (($urandom % 2) << 5)) : ($urandom % 256);
        cycle(1, 2'd0, bigEndian ? (a ^ 8'h03) : a, v, dn, er, 0, "R7");
      end else if (op == 6) begin
        a = wregs[$urandom % 5];
        cycle(1, 2'd2, a, $urandom, dn, er, 0, "R8");
      end else if (op == 7) begin
        a = hregs[$urandom % 3] + 8'(2 * ($urandom % 2));
        cycle(1, 2'd1, bigEndian ? (a ^ 8'h02) : a, $urandom % 65536, dn, er, 0, "R10");
      end else begin
        sz = 2'($urandom % 3);
        a = regs[$urandom % 7];
        if (sz == 2'd0) a = a + 8'($urandom % 4);
        if (sz == 2'd1) a = a + 8'(2 * ($urandom % 2));
        cycle(0, sz, a, 32'h0, dn, er, 1, "R10");
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "reqEnable", reqEnable, 0);
    chk("R1", "ctrlCfg", ctrlCfg, 0);
    chk("R1", "irqs", {30'h0, xferIrq, errIrq}, 0);
    @(negedge clk);
    rstN = 1'b1;
    cycle(0, 2'd2, 8'h0C, 0, 0, 0, 1, "R1");
    cycle(0, 2'd2, 8'h04, 0, 0, 0, 1, "R1");

    cycle(1, 2'd2, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, "R2");
    cycle(0, 2'd2, 8'h00, 0, 0, 0, 1, "R2");
    cycle(1, 2'd2, 8'h0C, 32'hA5A5_0F0F, 0, 0, 0, "R2");
    cycle(0, 2'd2, 8'h0C, 0, 0, 0, 1, "R2");
    cycle(1, 2'd0, 8'h1A, 8'h20, 0, 0, 0, "R3");   // bit 5 ignored: clears channel 0
    cycle(1, 2'd0, 8'h1B, 8'h1F, 0, 0, 0, "R3");
    cycle(1, 2'd0, 8'h19, 8'h04, 0, 0, 0, "R4");
    cycle(1, 2'd0, 8'h18, 8'h04, 0, 0, 0, "R4");
    cycle(1, 2'd0, 8'h19, 8'h04, 0, 0, 0, "R4");
    cycle(0, 2'd2, 8'h14, 0, 32'h0000_0210, 0, 1, "R7");
    cycle(1, 2'd0, 8'h1F, 8'h04, 0, 0, 0, "R5");
    cycle(1, 2'd0, 8'h1F, 8'h09, 0, 0, 0, "R5");
    cycle(0, 2'd2, 8'h24, 0, 0, 32'h0000_0110, 1, "R9");
    cycle(0, 2'd2, 8'h04, 0, 0, 0, 1, "R12");
    cycle(1, 2'd0, 8'h1E, 8'h04, 0, 0, 0, "R5");
    cycle(0, 2'd2, 8'h04, 0, 0, 0, 1, "R12");
    cycle(1, 2'd0, 8'h1B, 8'h40, 0, 0, 0, "R6");
    cycle(1, 2'd0, 8'h1A, 8'hC0, 0, 0, 0, "R6");
    cycle(1, 2'd0, 8'h1A, 8'h85, 0, 0, 0, "R6");
    cycle(1, 2'd0, 8'h1F, 8'h07, 32'h0000_0080, 0, 0, "R7");  // event wins over clear
    cycle(0, 2'd2, 8'h24, 0, 32'hFFFF_0000, 32'h00F0_0000, 1, "R8");
    cycle(1, 2'd2, 8'h24, 32'hFFFF_FFFF, 0, 0, 0, "R8");
    cycle(1, 2'd2, 8'h2C, 32'h0F0F_0F0F, 0, 0, 0, "R8");
    cycle(0, 2'd2, 8'h2C, 0, 0, 0, 1, "R8");
    cycle(1, 2'd0, 8'h1D, 8'h03, 0, 0, 0, "R11");
    cycle(0, 2'd2, 8'h00, 0, 0, 0, 0, "R11");
    cycle(1, 2'd0, 8'h1C, 8'h40, 0, 0, 0, "R11");
    cycle(1, 2'd2, 8'h18, 32'h0505_0202, 0, 0, 0, "R13"); // set beats clear on channels 5 and 2
    cycle(0, 2'd2, 8'h14, 0, 0, 0, 1, "R13");

    bigEndian = 1'b1;
    cycle(1, 2'd0, 8'h19, 8'h0A, 0, 0, 0, "R10");  // goes to 0x1A
    cycle(1, 2'd1, 8'h14, 32'h0000_BEEF, 0, 0, 0, "R10");
    cycle(0, 2'd1, 8'h16, 0, 0, 0, 1, "R10");
    cycle(0, 2'd1, 8'h14, 0, 0, 0, 1, "R10");
    cycle(0, 2'd0, 8'h0C, 0, 0, 0, 1, "R10");
    randomPhase(150);
    bigEndian = 1'b0;
    randomPhase(150);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule